// File: doc/BRIEF.md
# Page Write Load Controller

This block sits in front of a byte-wide non-volatile storage model. It collects a burst of byte writes that share one page and then starts a self-timed programming cycle that copies them into the storage. The active-low chip-select, write-strobe and read-strobe pins arrive already in the clock domain. They are registered once inside the block. A write stroke is the span in which chip-select and write-strobe are both low and the read-strobe is high.

The first accepted stroke opens a load and fixes the page. The page is the address bits above the low eight bits. Each later stroke to the same page restarts a load-window counter. A stroke to another page is dropped. When the window runs out with no stroke in progress, the block raises `busy`, waits out the programming time, and then copies every loaded byte into the storage, one offset per cycle. Offsets that were not loaded keep their old contents. A read port gives plain access to the storage contents, so the results can be seen.

Top module: `page_load_ctrl`

## Requirements
- R1: A byte is taken only by a stroke in which `cs_n`=0, `wr_n`=0 and `rd_n`=1. A stroke with `rd_n`=0 changes no stored byte.
- R2: The address is taken in the first cycle in which all three strobe conditions hold, which is the later of the two falling edges. The data is taken from the cycle in which the first of `cs_n`/`wr_n` rises.
- R3: A stroke lasting fewer than MIN_PULSE cycles stores nothing.
- R4: `addr[7:0]` selects the byte inside a 256-byte page, and `addr[ADDR_W-1:8]` is the page. In a load, a stroke to a page other than the first stroke's page is discarded and does not restart the window.
- R5: A load stays open while each stroke to the page starts within WIN_CYC cycles of the previous one. If WIN_CYC cycles pass with no stroke in progress, `busy` rises. The load itself has no overall length limit.
- R6: `busy` stays high for exactly PROG_CYC+256 cycles. After it falls, every loaded byte can be read back at its address.
- R7: A stroke that starts while `busy` is high stores nothing and does not open a new load.
- R8: Page bytes that were not loaded keep their old contents. If one offset is loaded twice, the later value is the one stored.
- R9: After reset `busy` is 0.
- R10: `rd_data` shows the stored byte at `rd_addr` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low; low blocks writes |
| addr | input | ADDR_W | Write address (page and offset) |
| din | input | 8 | Write data |
| rd_addr | input | ADDR_W | Storage read address |
| rd_data | output | 8 | Storage read data |
| busy | output | 1 | Programming in progress |

## Verification
Almost any wrong internal state shows at the ports only after the next commit. A bad page register, a bad valid bit or a bad offset writes the wrong storage byte. That byte can be read back as soon as `busy` falls. A bad window or programming counter shows earlier, as `busy` rising at the wrong time or staying high for the wrong number of cycles. The sweeps fill whole pages and then read every offset. Any misplaced or missing byte is therefore caught within one commit.

// File: rtl/pgl_pkg.sv
package pgl_pkg;
  localparam int OFF_W  = 8;
  localparam int PAGE_N = 1 << OFF_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_PROG   = 2'd2,
    ST_COMMIT = 2'd3
  } pgl_state_e;
endpackage

// File: rtl/pgl_strobe.sv
module pgl_strobe #(
  parameter int ADDR_W    = 10,
  parameter int MIN_PULSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              active,
  output logic              start,
  output logic              stroke_ok,
  output logic [ADDR_W-9:0] start_page,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [7:0]        cap_data
);
  localparam int PW = $clog2(MIN_PULSE + 1);

  logic              cs_q, wr_q, rd_q, act_d;
  logic [ADDR_W-1:0] addr_q, cap_addr_q, cap_addr_d;
  logic [7:0]        din_q;
  logic [PW-1:0]     plen_q, plen_d;
  logic              ending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      wr_q   <= 1'b1;
      rd_q   <= 1'b1;
      act_d  <= 1'b0;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      cs_q   <= cs_n;
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      act_d  <= active;
      addr_q <= addr;
      din_q  <= din;
    end
  end

  assign active     = !cs_q && !wr_q && rd_q;
  assign start      = active && !act_d;
  assign ending     = !active && act_d;
  assign stroke_ok  = ending && (plen_q >= PW'(MIN_PULSE));
  assign start_page = addr_q[ADDR_W-1:8];
  assign cap_addr   = cap_addr_q;
  assign cap_data   = din_q;

  always_comb begin
    plen_d     = plen_q;
    cap_addr_d = cap_addr_q;
    if (start) begin
      plen_d     = PW'(1);
      cap_addr_d = addr_q;
    end else if (active && plen_q < PW'(MIN_PULSE)) begin
      plen_d = plen_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plen_q     <= '0;
      cap_addr_q <= '0;
    end else begin
      plen_q     <= plen_d;
      cap_addr_q <= cap_addr_d;
    end
  end

  // R1
  accept_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stroke_ok |-> ($past(rd_q) && !$past(cs_q) && !$past(wr_q)));
endmodule

// File: rtl/pgl_pagebuf.sv
module pgl_pagebuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_off,
  input  logic [7:0] wr_data,
  input  logic       clr,
  input  logic [7:0] rd_off,
  output logic [7:0] rd_data,
  output logic       rd_valid
);
  import pgl_pkg::*;

  logic [7:0]        data_q [PAGE_N];
  logic [PAGE_N-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_off] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q         <= '0;
    else if (clr)   valid_q         <= '0;
    else if (wr_en) valid_q[wr_off] <= 1'b1;
  end

  assign rd_data  = data_q[rd_off];
  assign rd_valid = valid_q[rd_off];
endmodule

// File: rtl/pgl_array.sv
module pgl_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [7:0]        wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [7:0]        rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int ADDR_W    = 10,
  parameter int WIN_CYC   = 20,
  parameter int MIN_PULSE = 3,
  parameter int PROG_CYC  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);
  import pgl_pkg::*;

  localparam int PG_W    = ADDR_W - OFF_W;
  localparam int CNT_MAX = (WIN_CYC > PROG_CYC) ? ((WIN_CYC > PAGE_N) ? WIN_CYC : PAGE_N)
                                                : ((PROG_CYC > PAGE_N) ? PROG_CYC : PAGE_N);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  pgl_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic              pend_q, pend_d;

  logic              active, start, stroke_ok;
  logic [PG_W-1:0]   start_page;
  logic [ADDR_W-1:0] cap_addr;
  logic [7:0]        cap_data;
  logic              buf_we, buf_clr, buf_valid, arr_we;
  logic [7:0]        buf_rdata;

  pgl_strobe #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .din(din), .active(active), .start(start),
    .stroke_ok(stroke_ok), .start_page(start_page),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  pgl_pagebuf u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_off(cap_addr[7:0]),
    .wr_data(cap_data), .clr(buf_clr), .rd_off(cnt_q[7:0]),
    .rd_data(buf_rdata), .rd_valid(buf_valid)
  );

  pgl_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .we(arr_we), .wa({page_q, cnt_q[7:0]}), .wd(buf_rdata),
    .ra(rd_addr), .rd(rd_data)
  );

  assign busy = (state_q == ST_PROG) || (state_q == ST_COMMIT);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    page_d  = page_q;
    pend_d  = pend_q;
    buf_we  = 1'b0;
    buf_clr = 1'b0;
    arr_we  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          pend_d = 1'b1;
        end else if (stroke_ok && pend_q) begin
          buf_we  = 1'b1;
          page_d  = cap_addr[ADDR_W-1:OFF_W];
          cnt_d   = '0;
          pend_d  = 1'b0;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (start) begin
          pend_d = (start_page == page_q);
          if (start_page == page_q) cnt_d = '0;
        end else begin
          if (stroke_ok) begin
            buf_we = pend_q;
            pend_d = 1'b0;
          end
          if (!active && cnt_q >= CNT_W'(WIN_CYC - 1)) begin
            cnt_d   = '0;
            state_d = ST_PROG;
          end else if (cnt_q < CNT_W'(CNT_MAX)) begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_PROG: begin
        pend_d = 1'b0;
        if (cnt_q == CNT_W'(PROG_CYC - 1)) begin
          cnt_d   = '0;
          state_d = ST_COMMIT;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_COMMIT: begin
        pend_d = 1'b0;
        arr_we = buf_valid;
        if (cnt_q == CNT_W'(PAGE_N - 1)) begin
          buf_clr = 1'b1;
          cnt_d   = '0;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      page_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      page_q  <= page_d;
      pend_q  <= pend_d;
    end
  end

  logic [15:0] busy_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + 16'd1;
    else           busy_run_q <= '0;
  end

  // R7
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !busy);

  // R4
  page_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && state_q == ST_LOAD) |-> (cap_addr[ADDR_W-1:OFF_W] == page_q));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run_q == 16'(PROG_CYC + PAGE_N)));

  // R5
  prog_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(state_q) == ST_LOAD && !$past(active)));
endmodule

// File: tb/page_load_ctrl_tb.sv
module page_load_ctrl_tb;
  localparam int AW = 10, WIN = 20, MINP = 3, PROG = 50;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [7:0]    din = '0, rd_data;
  logic          busy;
  int            n_chk = 0, n_bad = 0, cyc = 0;

  page_load_ctrl #(.ADDR_W(AW), .WIN_CYC(WIN), .MIN_PULSE(MINP), .PROG_CYC(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] f0(int i); return 8'((i * 7 + 3) & 255); endfunction
  function automatic logic [7:0] g1(int i); return 8'((i * 13 + 91) & 255); endfunction
  function automatic logic [7:0] h0(int i); return 8'((i * 5 + 200) & 255); endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic stroke(int a, logic [7:0] d, int len, logic rdn = 1'b1);
    @(negedge clk);
    addr = AW'(a); din = d; cs_n = 1'b0; wr_n = 1'b0; rd_n = rdn;
    repeat (len) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    rd_n = 1'b1;
  endtask

  task automatic read_at(int a, output int v);
    rd_addr = AW'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic wait_rise(string req);
    int k = 0;
    while (!busy && k < 4 * WIN) begin @(negedge clk); k++; end
    check(req, int'(busy), 1);
  endtask

  task automatic wait_fall();
    while (busy) @(negedge clk);
  endtask

  task automatic commit_len();
    int k = 0;
    wait_rise("R5");
    while (busy && k < 1000) begin @(negedge clk); k++; end
    check("R6", k, PROG + 256);
  endtask

  task automatic check_page(int pg, string req, int kind);
    int v;
    for (int i = 0; i < 256; i++) begin
      read_at(pg * 256 + i, v);
      if (kind == 0) check(req, v, int'(f0(i)));
      else           check(req, v, int'(g1(i)));
    end
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R9
    check("R9", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", int'(busy), 0);

    // page 0 full load; R5 window stays open during the burst
    for (int i = 0; i < 256; i++) begin
      stroke(i, f0(i), 4);
      if (i % 64 == 63) check("R5", int'(busy), 0);
    end
    repeat (5) @(negedge clk);
    check("R5", int'(busy), 0);
    commit_len();
    check_page(0, "R6/R10", 0);

    // page 1 full load
    for (int i = 0; i < 256; i++) stroke(256 + i, g1(i), 5);
    commit_len();
    check_page(1, "R6/R10", 1);

    // page 0 partial load with stray, short and blocked strokes
    stroke(0, 8'h11, 4);
    for (int i = 1; i < 32; i++) begin
      if (i == 10) stroke(256 + 5, 8'hEE, 4);         // R4 other page
      if (i == 20) stroke(40, 8'h77, 1);               // R3 short pulse
      if (i == 25) stroke(41, 8'h66, 4, 1'b0);         // R1 read strobe low
      stroke(i, h0(i), 4);
    end
    stroke(0, 8'h22, 4);                               // R8 later value wins
    wait_rise("R5");
    stroke(256 + 7, 8'h55, 4);                         // R7 while busy
    wait_fall();
    repeat (2 * WIN) @(negedge clk);
    check("R7", int'(busy), 0);
    read_at(0, v);   check("R8", v, 8'h22);
    for (int i = 1; i < 32; i++) begin read_at(i, v); check("R2", v, int'(h0(i))); end
    for (int i = 32; i < 256; i++) begin read_at(i, v); check("R8", v, int'(f0(i))); end
    read_at(40, v);  check("R3", v, int'(f0(40)));
    read_at(41, v);  check("R1", v, int'(f0(41)));
    read_at(261, v); check("R4", v, int'(g1(5)));
    read_at(263, v); check("R7", v, int'(g1(7)));

    // R2: write strobe falls first, chip select later; chip select rises first
    @(negedge clk);
    addr = AW'(256 + 99); din = 8'hAA; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = AW'(256 + 20); din = 8'h3C; cs_n = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    din = 8'hC3; addr = AW'(256 + 99); wr_n = 1'b1;
    repeat (2) @(negedge clk);
    commit_len();
    read_at(256 + 20, v); check("R2", v, 8'h3C);
    read_at(256 + 99, v); check("R2", v, int'(g1(99)));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule